// File: doc/BRIEF.md
# AAL-5 Cell Segmenter with Trailer

This block cuts one packet, which arrives as a byte stream closed by an end marker, into a run of 53-byte ATM cells. Each cell is a 5-byte header followed by a 48-byte payload. On request the block first writes a fixed encapsulation header of its own at the front of the payload. It keeps a CRC-32 and a byte count running over the whole protocol data unit. At the end of the packet it zero-pads and appends the 8-byte AAL-5 trailer. When the tail of the data leaves no room for the trailer, it emits one more cell that holds only padding and the trailer.

Each cell's payload is staged in a 48-byte buffer. The header goes out only after the whole payload has been staged, so the end-of-message bit is already known when the header leaves. The input and output phases never overlap. The input stream handshakes on `in_valid`/`in_ready`, and `in_ready` stays low whenever the block is not accepting packet data. The output stream handshakes on `out_valid`/`out_ready`. While `out_ready` is low the block holds `out_valid` and `out_data` unchanged. The configuration pins are plain levels. They must stay stable from the first byte of a packet until that packet's last cell has left.

Top module: `aal5_segmenter`

## Requirements
- R1: Output is a sequence of cells of exactly 53 transferred bytes. The first 5 bytes of each cell come from `cfg_hdr`, most significant byte first, and the other 48 are payload. `out_cell_end` is high only together with the handshake of the 53rd byte of a cell.
- R2: An output byte moves only when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` stays high and `out_data` does not change. An input byte is taken only when `in_valid` and `in_ready` are both high.
- R3: `cfg_encap` selects the header placed at the start of the first cell's payload. 0 selects no header. 1 selects an 8-byte LLC/SNAP header AA AA 03 00 00 00 08 00. 2 selects a 2-byte PPP protocol field 00 21. 3 selects a 4-byte PPP-in-HDLC-style header FF 03 00 21. The first cell therefore takes 48, 40, 46 or 44 packet bytes.
- R4: `in_ready` is low whenever the block is writing header, padding or trailer bytes or is sending a cell, and it is never high in a cycle where `out_valid` is high.
- R5: When the last packet byte leaves at most 40 payload bytes used in its cell, that cell is zero-padded up to payload offset 40. The trailer fills offsets 40 to 47, and this cell is the final one.
- R6: When the last packet byte leaves more than 40 payload bytes used, that cell is zero-padded to 48 bytes. One further cell follows, carrying 40 zero bytes and then the trailer.
- R7: The trailer is, in order: `cfg_uu`, `cfg_cpi`, the length field most significant byte first, and the CRC most significant byte first.
- R8: The length field equals the number of encapsulation-header bytes plus packet bytes, modulo 65536. Padding and trailer are not counted.
- R9: The CRC uses the generator 0x04C11DB7, processed most significant bit first, with an all-ones start value. It covers every payload byte of the unit (header, data, padding and the first 4 trailer bytes), and the bitwise complement of the result is sent. It restarts for every packet.
- R10: Bit 1 of header byte 3 (the fourth byte sent) is forced to 1 in the cell that carries the trailer and forced to 0 in every other cell. All other header bits pass from `cfg_hdr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_encap | input | 2 | Encapsulation select (0 none, 1 LLC, 2 PPP, 3 PPP with address/control) |
| cfg_uu | input | 8 | CPCS user-to-user byte for the trailer |
| cfg_cpi | input | 8 | Common part indicator byte for the trailer |
| cfg_hdr | input | 40 | Cell header template, first byte in bits 39:32 |
| in_valid | input | 1 | Packet byte valid |
| in_ready | output | 1 | Block accepts a packet byte |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Marks the final byte of the packet |
| out_valid | output | 1 | Cell byte valid |
| out_ready | input | 1 | Downstream accepts a cell byte |
| out_data | output | 8 | Cell byte |
| out_cell_end | output | 1 | High with the handshake of a cell's 53rd byte |

## Verification
The bench sweeps every packet length from 1 to 90 bytes under all four encapsulation modes. This places the last data byte at every payload offset, including the boundaries at 40, 41 and 48 used bytes. A design that compared against 39 instead of 40 would add a needless extra cell at exactly 40 bytes. One that missed the full-cell case would put the trailer on top of data. The bench compares each cell byte for byte against a payload, padding, length and CRC that it builds arithmetically. A wrong CRC span, for example one that skipped the padding or included the CRC bytes, shows up as a mismatch in the last four bytes. A length that counted padding shows up in the length bytes. Some packets run with random gaps on both streams, which catches a byte lost or repeated under back-pressure. The header templates alternate bit 1 of byte 3, so an end-of-message bit that was passed through instead of forced is caught in both directions.

// File: rtl/aal5_seg_pkg.sv
package aal5_seg_pkg;

  localparam int unsigned LEN_W = 16;
  localparam logic [31:0] CRC_GEN = 32'h04C11DB7;

  typedef enum logic [2:0] {
    ST_START,
    ST_ENC,
    ST_DATA,
    ST_PAD,
    ST_TRL,
    ST_SEND
  } fill_st_e;

  // One byte of the MSB-first CRC-32 shift.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_GEN;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  // Number of encapsulation bytes for a mode.
  function automatic logic [3:0] encap_len(input logic [1:0] mode);
    case (mode)
      2'd1:    return 4'd8;
      2'd2:    return 4'd2;
      2'd3:    return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

  // Encapsulation byte at index idx for a mode.
  function automatic logic [7:0] encap_byte(input logic [1:0] mode, input logic [2:0] idx);
    logic [7:0] b;
    b = 8'h00;
    case (mode)
      2'd1: begin
        case (idx)
          3'd0, 3'd1: b = 8'hAA;
          3'd2:       b = 8'h03;
          3'd6:       b = 8'h08;
          default:    b = 8'h00;
        endcase
      end
      2'd2: b = (idx == 3'd1) ? 8'h21 : 8'h00;
      2'd3: begin
        case (idx)
          3'd0:    b = 8'hFF;
          3'd1:    b = 8'h03;
          3'd3:    b = 8'h21;
          default: b = 8'h00;
        endcase
      end
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/aal5_seg_crc.sv
module aal5_seg_crc
  import aal5_seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             crc_en,
  input  logic             len_en,
  input  logic [7:0]       din,
  output logic [31:0]      crc,
  output logic [LEN_W-1:0] len
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '1;
      len <= '0;
    end else if (clr) begin
      crc <= '1;
      len <= '0;
    end else begin
      if (crc_en) crc <= crc32_step(crc, din);
      if (len_en) len <= len + LEN_W'(1);
    end
  end

endmodule

// File: rtl/aal5_seg_buf.sv
module aal5_seg_buf #(
  parameter int unsigned PAYLOAD_BYTES = 48,
  localparam int unsigned IDX_W = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [7:0]       wd,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [7:0]       rd_data
);

  logic [7:0] mem [PAYLOAD_BYTES];

  always_ff @(posedge clk) begin
    if (we && (wr_addr < IDX_W'(PAYLOAD_BYTES))) mem[wr_addr] <= wd;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < PAYLOAD_BYTES; k++) begin
      if (rd_addr == IDX_W'(k)) rd_data = mem[k];
    end
  end

endmodule

// File: rtl/aal5_seg_emit.sv
module aal5_seg_emit #(
  parameter int unsigned HDR_BYTES     = 5,
  parameter int unsigned PAYLOAD_BYTES = 48,
  parameter int unsigned PTI_BYTE      = 3,
  localparam int unsigned CELL_BYTES = HDR_BYTES + PAYLOAD_BYTES,
  localparam int unsigned POS_W      = $clog2(CELL_BYTES),
  localparam int unsigned IDX_W      = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   active,
  input  logic                   eom,
  input  logic [8*HDR_BYTES-1:0] hdr,
  input  logic [7:0]             rd_data,
  output logic [IDX_W-1:0]       rd_addr,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [7:0]             out_data,
  output logic                   out_cell_end
);

  logic [POS_W-1:0] pos;
  logic             fire;
  logic             at_end;
  logic [7:0]       hb;

  assign fire   = active && out_ready;
  assign at_end = (pos == POS_W'(CELL_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (fire) pos <= at_end ? '0 : pos + POS_W'(1);
  end

  always_comb begin
    hb = 8'h00;
    for (int k = 0; k < HDR_BYTES; k++) begin
      if (pos == POS_W'(k)) begin
        hb = hdr[8*(HDR_BYTES-1-k) +: 8];
        if (k == PTI_BYTE) hb[1] = eom;
      end
    end
  end

  assign rd_addr      = IDX_W'(pos - POS_W'(HDR_BYTES));
  assign out_valid    = active;
  assign out_data     = (pos < POS_W'(HDR_BYTES)) ? hb : rd_data;
  assign out_cell_end = fire && at_end;

endmodule

// File: rtl/aal5_segmenter.sv
module aal5_segmenter
  import aal5_seg_pkg::*;
#(
  parameter int unsigned HDR_BYTES     = 5,
  parameter int unsigned PAYLOAD_BYTES = 48,
  parameter int unsigned TRL_BYTES     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_encap,
  input  logic [7:0]             cfg_uu,
  input  logic [7:0]             cfg_cpi,
  input  logic [8*HDR_BYTES-1:0] cfg_hdr,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  input  logic                   in_last,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   out_cell_end
);

  localparam int unsigned IDX_W     = $clog2(PAYLOAD_BYTES + 1);
  localparam int unsigned SUB_W     = $clog2(TRL_BYTES);
  localparam int unsigned PAD_LIMIT = PAYLOAD_BYTES - TRL_BYTES;

  fill_st_e         st;
  logic [IDX_W-1:0] wr_idx;
  logic [SUB_W-1:0] sub_idx;
  logic             trl_here;   // current cell carries the trailer
  logic             pend_trl;   // a trailer-only cell must follow

  logic             buf_we;
  logic [7:0]       buf_wd;
  logic [IDX_W-1:0] rd_addr;
  logic [7:0]       rd_data;
  logic             crc_clr, crc_en, len_en;
  logic [31:0]      crc_val;
  logic [LEN_W-1:0] len_val;
  logic [3:0]       enc_n;
  logic             in_fire;
  logic [IDX_W-1:0] pad_target;
  logic [7:0]       trl_b;

  assign enc_n      = encap_len(cfg_encap);
  assign in_ready   = (st == ST_DATA);
  assign in_fire    = in_valid && in_ready;
  assign pad_target = trl_here ? IDX_W'(PAD_LIMIT) : IDX_W'(PAYLOAD_BYTES);

  // Trailer byte selection
  always_comb begin
    case (sub_idx)
      SUB_W'(0): trl_b = cfg_uu;
      SUB_W'(1): trl_b = cfg_cpi;
      SUB_W'(2): trl_b = len_val[15:8];
      SUB_W'(3): trl_b = len_val[7:0];
      SUB_W'(4): trl_b = ~crc_val[31:24];
      SUB_W'(5): trl_b = ~crc_val[23:16];
      SUB_W'(6): trl_b = ~crc_val[15:8];
      default:   trl_b = ~crc_val[7:0];
    endcase
  end

  // Write-side control
  always_comb begin
    buf_we  = 1'b0;
    buf_wd  = 8'h00;
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    len_en  = 1'b0;
    case (st)
      ST_START: crc_clr = 1'b1;
      ST_ENC: begin
        buf_we = 1'b1;
        buf_wd = encap_byte(cfg_encap, 3'(sub_idx));
        crc_en = 1'b1;
        len_en = 1'b1;
      end
      ST_DATA: begin
        if (in_fire) begin
          buf_we = 1'b1;
          buf_wd = in_data;
          crc_en = 1'b1;
          len_en = 1'b1;
        end
      end
      ST_PAD: begin
        if (wr_idx != pad_target) begin
          buf_we = 1'b1;
          crc_en = 1'b1;
        end
      end
      ST_TRL: begin
        buf_we = 1'b1;
        buf_wd = trl_b;
        crc_en = (sub_idx < SUB_W'(4));
      end
      default: ;
    endcase
  end

  // Fill sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_START;
      wr_idx   <= '0;
      sub_idx  <= '0;
      trl_here <= 1'b0;
      pend_trl <= 1'b0;
    end else begin
      case (st)
        ST_START: begin
          wr_idx   <= '0;
          sub_idx  <= '0;
          trl_here <= 1'b0;
          pend_trl <= 1'b0;
          st       <= (enc_n != 4'd0) ? ST_ENC : ST_DATA;
        end
        ST_ENC: begin
          wr_idx <= wr_idx + IDX_W'(1);
          if ({1'b0, sub_idx} == SUB_W'(enc_n - 4'd1)) begin
            sub_idx <= '0;
            st      <= ST_DATA;
          end else begin
            sub_idx <= sub_idx + SUB_W'(1);
          end
        end
        ST_DATA: begin
          if (in_fire) begin
            wr_idx <= wr_idx + IDX_W'(1);
            if (in_last) begin
              if (wr_idx < IDX_W'(PAD_LIMIT)) trl_here <= 1'b1;
              else                            pend_trl <= 1'b1;
              st <= ST_PAD;
            end else if (wr_idx == IDX_W'(PAYLOAD_BYTES - 1)) begin
              st <= ST_SEND;
            end
          end
        end
        ST_PAD: begin
          if (wr_idx == pad_target) begin
            sub_idx <= '0;
            st      <= trl_here ? ST_TRL : ST_SEND;
          end else begin
            wr_idx <= wr_idx + IDX_W'(1);
          end
        end
        ST_TRL: begin
          wr_idx  <= wr_idx + IDX_W'(1);
          sub_idx <= sub_idx + SUB_W'(1);
          if (sub_idx == SUB_W'(TRL_BYTES - 1)) st <= ST_SEND;
        end
        ST_SEND: begin
          if (out_cell_end) begin
            wr_idx <= '0;
            if (trl_here) begin
              st <= ST_START;
            end else if (pend_trl) begin
              trl_here <= 1'b1;
              pend_trl <= 1'b0;
              st       <= ST_PAD;
            end else begin
              st <= ST_DATA;
            end
          end
        end
        default: st <= ST_START;
      endcase
    end
  end

  aal5_seg_crc u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (crc_clr),
    .crc_en (crc_en),
    .len_en (len_en),
    .din    (buf_wd),
    .crc    (crc_val),
    .len    (len_val)
  );

  aal5_seg_buf #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_buf (
    .clk     (clk),
    .we      (buf_we),
    .wr_addr (wr_idx),
    .wd      (buf_wd),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  aal5_seg_emit #(
    .HDR_BYTES     (HDR_BYTES),
    .PAYLOAD_BYTES (PAYLOAD_BYTES),
    .PTI_BYTE      (3)
  ) u_emit (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (st == ST_SEND),
    .eom          (trl_here),
    .hdr          (cfg_hdr),
    .rd_data      (rd_data),
    .rd_addr      (rd_addr),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_cell_end (out_cell_end)
  );

endmodule

// File: rtl/aal5_seg_checker.sv
module aal5_seg_checker #(
  parameter int unsigned PAYLOAD_BYTES = 48,
  localparam int unsigned IDX_W = $clog2(PAYLOAD_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_cell_end,
  input logic [IDX_W-1:0] wr_idx,
  input logic             trl_here,
  input logic             pend_trl
);

  p_cellend_hs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_cell_end |-> (out_valid && out_ready));

  p_gap_after_cell_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_cell_end |=> !out_valid);

  p_hold_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  p_ready_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx <= IDX_W'(PAYLOAD_BYTES));

  p_single_trailer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_trl |-> !trl_here);

endmodule

bind aal5_segmenter aal5_seg_checker #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_cell_end (out_cell_end),
  .wr_idx       (wr_idx),
  .trl_here     (trl_here),
  .pend_trl     (pend_trl)
);

// File: tb/aal5_segmenter_tb.sv
`timescale 1ns/1ps
module aal5_segmenter_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_encap;
  logic [7:0]  cfg_uu, cfg_cpi;
  logic [39:0] cfg_hdr;
  logic        in_valid, in_ready, in_last;
  logic [7:0]  in_data;
  logic        out_valid, out_ready, out_cell_end;
  logic [7:0]  out_data;

  always #2.5 clk = ~clk;

  aal5_segmenter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_encap(cfg_encap), .cfg_uu(cfg_uu),
    .cfg_cpi(cfg_cpi), .cfg_hdr(cfg_hdr), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_cell_end(out_cell_end)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_b[$];
  string      exp_t[$];
  int acc_cnt, first_out_acc, r4_viol, in_cell, cell_no;
  bit saw_out, stall_mode, cell_bad, done_flag;
  string bad_tag;
  int bad_pos, bad_act, bad_exp;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] x;
    x = c ^ {b, 24'h0};
    for (int k = 0; k < 8; k++) x = x[31] ? ((x << 1) ^ 32'h04C11DB7) : (x << 1);
    return x;
  endfunction

  function automatic logic [7:0] dbyte(input int m, input int n, input int i);
    return 8'(i * 37 + n * 11 + m * 5 + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input string t);
    exp_b.push_back(b);
    exp_t.push_back(t);
  endtask

  // Build the expected cell stream for one packet and drive it.
  task automatic run_packet(input int m, input int n);
    logic [7:0] pdu[$];
    logic [31:0] c;
    int e, L, total, cells, data_cells;
    logic [39:0] hdr;
    cfg_encap = 2'(m);
    cfg_uu    = 8'(n ^ 8'h5A);
    cfg_cpi   = 8'(m + 8'h30);
    hdr       = {8'(n), 8'h12, 8'h34, 8'(n * 3), 8'hA7};
    cfg_hdr   = hdr;
    // R3: encapsulation bytes
    case (m)
      1: begin pdu.push_back(8'hAA); pdu.push_back(8'hAA); pdu.push_back(8'h03);
               pdu.push_back(8'h00); pdu.push_back(8'h00); pdu.push_back(8'h00);
               pdu.push_back(8'h08); pdu.push_back(8'h00); end
      2: begin pdu.push_back(8'h00); pdu.push_back(8'h21); end
      3: begin pdu.push_back(8'hFF); pdu.push_back(8'h03);
               pdu.push_back(8'h00); pdu.push_back(8'h21); end
      default: ;
    endcase
    e = pdu.size();
    for (int i = 0; i < n; i++) pdu.push_back(dbyte(m, n, i));
    L = e + n;
    total = ((L + 8 + 47) / 48) * 48;
    cells = total / 48;
    data_cells = (L + 47) / 48;
    while (pdu.size() < total - 8) pdu.push_back(8'h00);
    pdu.push_back(cfg_uu);
    pdu.push_back(cfg_cpi);
    pdu.push_back(8'(L >> 8));   // R8 length
    pdu.push_back(8'(L));
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < total - 4; i++) c = crc_step(c, pdu[i]);
    c = ~c;                      // R9
    pdu.push_back(c[31:24]); pdu.push_back(c[23:16]);
    pdu.push_back(c[15:8]);  pdu.push_back(c[7:0]);
    for (int k = 0; k < cells; k++) begin
      for (int h = 0; h < 5; h++) begin
        logic [7:0] hb;
        hb = hdr[8*(4-h) +: 8];
        if (h == 3) begin
          hb[1] = (k == cells - 1);
          push(hb, "R10");
        end else push(hb, "R1");
      end
      for (int j = 0; j < 48; j++) begin
        int a;
        a = k * 48 + j;
        if (a < e)              push(pdu[a], "R3");
        else if (a < L)         push(pdu[a], "R1");
        else if (a < total - 8) push(pdu[a], (k >= data_cells) ? "R6" : "R5");
        else if (a < total - 6) push(pdu[a], "R7");
        else if (a < total - 4) push(pdu[a], "R8");
        else                    push(pdu[a], "R9");
      end
    end
    acc_cnt = 0;
    saw_out = 1'b0;
    for (int i = 0; i < n; i++) begin
      done_flag = 1'b0;
      while (!done_flag) begin
        @(negedge clk);
        if (stall_mode && lf[3]) begin
          in_valid = 1'b0;
        end else begin
          in_valid = 1'b1;
          in_data  = dbyte(m, n, i);
          in_last  = (i == n - 1);
          if (in_ready) begin
            done_flag = 1'b1;
            acc_cnt++;
          end
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    while (exp_b.size() != 0) @(negedge clk);
    // R3: packet bytes taken into the first cell before it is sent
    if (n + e > 48)
      check(first_out_acc == 48 - e, "R3", $sformatf("first-cell fill m=%0d n=%0d", m, n),
            first_out_acc, 48 - e);
  endtask

  // Output monitor: drives out_ready, samples after the settle point.
  initial begin
    out_ready = 1'b0;
    in_cell = 0; cell_no = 0; cell_bad = 1'b0; r4_viol = 0;
    forever begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_ready = stall_mode ? lf[1] : 1'b1;   // R2 back-pressure
      #1;
      if (rst_n && out_valid && in_ready) r4_viol++;
      if (rst_n && out_valid && !saw_out) begin
        saw_out = 1'b1;
        first_out_acc = acc_cnt;
      end
      if (rst_n && out_valid && out_ready) begin
        logic [7:0] eb;
        string      et;
        if (exp_b.size() == 0) begin
          check(1'b0, "R1", "unexpected output byte", out_data, 0);
        end else begin
          eb = exp_b.pop_front();
          et = exp_t.pop_front();
          if (out_data !== eb && !cell_bad) begin
            cell_bad = 1'b1; bad_tag = et; bad_pos = in_cell;
            bad_act = out_data; bad_exp = eb;
          end
          if (out_cell_end !== (in_cell == 52) && !cell_bad) begin
            cell_bad = 1'b1; bad_tag = "R1"; bad_pos = in_cell;
            bad_act = out_cell_end; bad_exp = (in_cell == 52);
          end
          in_cell++;
          if (in_cell == 53) begin
            check(!cell_bad, cell_bad ? bad_tag : "R1",
                  $sformatf("cell %0d byte %0d%s", cell_no, bad_pos, stall_mode ? " (R2 stalls)" : ""),
                  bad_act, bad_exp);
            in_cell = 0; cell_no++; cell_bad = 1'b0;
          end
        end
      end else if (rst_n && out_cell_end) begin
        check(1'b0, "R1", "cell end without handshake", 1, 0);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
    stall_mode = 1'b0;
    cfg_encap = 2'd0; cfg_uu = 8'h00; cfg_cpi = 8'h00; cfg_hdr = '0;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    check(in_ready == 1'b0, "R4", "reset in_ready", in_ready, 0);
    check(out_cell_end == 1'b0, "R1", "reset out_cell_end", out_cell_end, 0);
    rst_n = 1'b1;
    // Sweep every length over every mode: covers R5, R6 boundaries.
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 90; n++) begin
        stall_mode = (n % 6 == 5);
        run_packet(m, n);
      end
    end
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    check(r4_viol == 0, "R4", "in_ready while out_valid", r4_viol, 0);
    check(exp_b.size() == 0, "R1", "leftover expected bytes", exp_b.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule